// File: doc/BRIEF.md
# Hidden LED Test Window Sequencer

This block produces a short, low-level test current on LED outputs that are meant to stay dark, so that open-circuit and short faults can be sensed without visible light. It runs in the oscillator clock domain. An asynchronous blanking input passes through a two-stage synchroniser and an edge detector. When blanking falls and the feature is armed, a test window opens. The feature is armed when the blanking pin is configured as an output enable and the current-select field is non-zero.

The window closes at whichever comes first: a programmed number of oscillator clocks, or the synchronised rising edge of blanking. The close always produces a single-cycle capture strobe, which tells the status capture unit to latch the selected fault data. The test current level is a 2-bit code for the analog sinks. It is sampled when the window opens and held until the window closes. While the feature is armed, a hold output keeps the leak detector disabled.

Top module: `idm_window_seq`

## Requirements
- R1: `blank_in` passes through a two-flop synchroniser. After `blank_in` falls between two clock edges, `test_sink_en` first reads high after the third rising clock edge.
- R2: A window opens only if `oe_mode` is 1 and `cur_sel` is not 00 when the synchronised falling edge is seen. Otherwise `test_sink_en` and `capture_stb` stay low.
- R3: With no early close, `test_sink_en` stays high for exactly 16·2^`win_sel`+1 clocks: 17, 33, 65 or 129 for `win_sel` 00, 01, 10 or 11.
- R4: If blanking is held low for N clocks, with N below the programmed length, the window lasts exactly N clocks.
- R5: Each window produces exactly one `capture_stb` pulse, one clock wide, in the clock right after the last high clock of `test_sink_en`. This holds when the early close and the count expiry fall on the same clock.
- R6: While `test_sink_en` is high, `test_sink_code` equals the `cur_sel` value sampled when the window opened. It does not follow later changes of `cur_sel`. While `test_sink_en` is low, `test_sink_code` is 00.
- R7: At most one window opens per low period of blanking. After the count expires with blanking still low, `test_sink_en` stays low.
- R8: `leak_det_hold` equals `oe_mode` AND (`cur_sel` != 00), combinationally.
- R9: During and right after reset, `test_sink_en` and `capture_stb` are low and `test_sink_code` is 00.
- R10: The window length is sampled when the window opens. A change of `win_sel` during a window does not alter that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank_in | input | 1 | Asynchronous blanking input |
| cur_sel | input | 2 | Test current select; 00 disables |
| win_sel | input | 2 | Window length select |
| oe_mode | input | 1 | 1 = blanking used as output enable |
| test_sink_en | output | 1 | Enables the analog test sinks |
| test_sink_code | output | 2 | Test current code for the sinks |
| capture_stb | output | 1 | One-cycle status capture strobe |
| leak_det_hold | output | 1 | Holds the leak detector disabled |

## Verification
Two events can land on the same clock edge: the early close caused by blanking rising, and the expiry of the window count. The bench provokes this by holding blanking low for exactly the programmed length, for two different lengths. It then checks three things: the window length equals that count, exactly one capture strobe appears, and the strobe falls in the clock right after the last window clock. Runs one clock shorter and one clock longer than the programmed length bracket the coincidence, so an off-by-one on either path is detected.

// File: rtl/idm_seq_pkg.sv
package idm_seq_pkg;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = 8;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Window length in oscillator clocks for a time-select code.
  function automatic cnt_t win_len(input sel_t code);
    case (code)
      2'b00:   win_len = cnt_t'(17);
      2'b01:   win_len = cnt_t'(33);
      2'b10:   win_len = cnt_t'(65);
      default: win_len = cnt_t'(129);
    endcase
  endfunction

  // Feature armed: enable mode and a non-zero current select.
  function automatic logic armed(input logic mode, input sel_t cur);
    armed = mode && (cur != '0);
  endfunction
endpackage

// File: rtl/blank_sync.sv
module blank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic fall_evt,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_out;

  assign sync_out = chain[STAGES-1];
  assign fall_evt = prev_q & ~sync_out;
  assign rise_evt = ~prev_q & sync_out;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt); // R7
endmodule

// File: rtl/window_timer.sv
module window_timer
  import idm_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  cnt_t len_in,
  output logic active,
  output logic done_stb
);
  cnt_t cnt_q;
  cnt_t len_q;
  logic last_cnt;

  assign last_cnt = (cnt_q == len_q - cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done_stb <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else begin
      done_stb <= 1'b0;
      if (active) begin
        if (abort || last_cnt) begin
          active   <= 1'b0;
          done_stb <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + cnt_t'(1);
        end
      end else if (start) begin
        active <= 1'b1;
        cnt_q  <= '0;
        len_q  <= len_in;
      end
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < len_q)); // R3
  AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (active && abort) |=> (!active && done_stb)); // R4
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(len_q)); // R10
endmodule

// File: rtl/idm_window_seq.sv
module idm_window_seq
  import idm_seq_pkg::*;
(
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       blank_in,
  input  logic [1:0] cur_sel,
  input  logic [1:0] win_sel,
  input  logic       oe_mode,
  output logic       test_sink_en,
  output logic [1:0] test_sink_code,
  output logic       capture_stb
  ,output logic      leak_det_hold
);
  logic blank_s;
  logic fall_evt;
  logic rise_evt;
  logic start_evt;
  logic win_active;
  logic win_done;
  sel_t code_q;

  blank_sync #(.STAGES(2)) u_sync (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .async_in (blank_in),
    .sync_out (blank_s),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  assign start_evt = fall_evt && armed(oe_mode, cur_sel) && !win_active;

  window_timer u_timer (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .abort    (rise_evt),
    .len_in   (win_len(win_sel)),
    .active   (win_active),
    .done_stb (win_done)
  );

  always_ff @(posedge osc_clk or negedge rst_n)
    if (!rst_n)         code_q <= '0;
    else if (start_evt) code_q <= cur_sel;

  assign test_sink_en   = win_active;
  assign test_sink_code = win_active ? code_q : 2'b00;
  assign capture_stb    = win_done;
  assign leak_det_hold  = armed(oe_mode, cur_sel);

  AST_START_ON_FALL: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(test_sink_en) |-> $past(fall_evt)); // R1
  AST_START_ARMED: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(test_sink_en) |-> $past(oe_mode)); // R2
  AST_CAP_SINGLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    capture_stb |=> !capture_stb); // R5
  AST_CAP_AT_END: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(test_sink_en) |-> capture_stb); // R5
  AST_CODE_VALID: assert property (@(posedge osc_clk) disable iff (!rst_n)
    test_sink_en |-> (test_sink_code != 2'b00)); // R6
  AST_CODE_HELD: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (test_sink_en && $past(test_sink_en)) |-> $stable(test_sink_code)); // R6
endmodule

// File: tb/tb_idm_window_seq.sv
module tb_idm_window_seq;
  logic       osc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blank_in = 1'b1;
  logic [1:0] cur_sel = 2'b00;
  logic [1:0] win_sel = 2'b00;
  logic       oe_mode = 1'b0;
  logic       test_sink_en;
  logic [1:0] test_sink_code;
  logic       capture_stb;
  logic       leak_det_hold;

  int total = 0;
  int bad = 0;

  always #4 osc_clk = ~osc_clk;

  idm_window_seq dut (
    .osc_clk(osc_clk), .rst_n(rst_n), .blank_in(blank_in),
    .cur_sel(cur_sel), .win_sel(win_sel), .oe_mode(oe_mode),
    .test_sink_en(test_sink_en), .test_sink_code(test_sink_code),
    .capture_stb(capture_stb), .leak_det_hold(leak_det_hold)
  );

  // vector: {mode, cur, tim, low_clocks}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 2'b01, 2'b00, 8'd40},
    {1'b1, 2'b10, 2'b01, 8'd40},
    {1'b1, 2'b11, 2'b10, 8'd100},
    {1'b1, 2'b01, 2'b11, 8'd200},
    {1'b1, 2'b10, 2'b11, 8'd50},
    {1'b1, 2'b11, 2'b00, 8'd5},
    {1'b1, 2'b01, 2'b00, 8'd17},
    {1'b1, 2'b11, 2'b01, 8'd33},
    {1'b0, 2'b11, 2'b00, 8'd40},
    {1'b1, 2'b00, 2'b11, 8'd40},
    {1'b1, 2'b10, 2'b00, 8'd16},
    {1'b1, 2'b10, 2'b00, 8'd18}
  };

  // monitor
  int         sink_cnt, cap_cnt, misplace, code_var, idle_code;
  logic       prev_sink = 1'b0;
  logic [1:0] first_code;
  bit         seen;

  always @(negedge osc_clk) begin
    if (rst_n) begin
      if (test_sink_en) begin
        sink_cnt++;
        if (!seen) begin first_code = test_sink_code; seen = 1; end
        else if (test_sink_code != first_code) code_var++;
      end else if (test_sink_code != 2'b00) idle_code++;
      if (capture_stb) begin
        cap_cnt++;
        if (!prev_sink) misplace++;
      end
      prev_sink = test_sink_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge osc_clk);
    sink_cnt = 0; cap_cnt = 0; misplace = 0; code_var = 0; idle_code = 0;
    seen = 0;
  endtask

  function automatic int exp_len(input logic [1:0] t);
    return (16 << t) + 1;
  endfunction

  task automatic low_pulse(input int n);
    @(negedge osc_clk) blank_in = 1'b0;
    repeat (n) @(negedge osc_clk);
    blank_in = 1'b1;
    repeat (12) @(negedge osc_clk);
  endtask

  initial begin
    repeat (200000) @(posedge osc_clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    logic en;
    repeat (3) @(negedge osc_clk);
    // R9 reset state
    check("R9 sink_en in reset", int'(test_sink_en), 0);
    check("R9 capture in reset", int'(capture_stb), 0);
    check("R9 code in reset", int'(test_sink_code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge osc_clk);
    check("R9 sink_en after reset", int'(test_sink_en), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic m; logic [1:0] c, t; int n, el;
      {m, c, t} = VEC[i][12:8];
      n = int'(VEC[i][7:0]);
      @(negedge osc_clk);
      oe_mode = m; cur_sel = c; win_sel = t;
      clear_mon();
      low_pulse(n);
      en = m && (c != 2'b00);
      el = en ? ((n < exp_len(t)) ? n : exp_len(t)) : 0;
      check($sformatf("R3 R4 R7 vec%0d window length", i), sink_cnt, el);
      check($sformatf("R2 R5 vec%0d captures", i), cap_cnt, en ? 1 : 0);
      check($sformatf("R5 vec%0d capture placement", i), misplace, 0);
      if (en) check($sformatf("R6 vec%0d code", i), int'(first_code), int'(c));
      check($sformatf("R6 vec%0d code stable/idle", i), code_var + idle_code, 0);
    end

    // R1 start latency
    @(negedge osc_clk);
    oe_mode = 1; cur_sel = 2'b01; win_sel = 2'b00;
    @(negedge osc_clk) blank_in = 1'b0;
    k = 0;
    while (!test_sink_en && k < 10) begin @(negedge osc_clk); k++; end
    check("R1 start latency", k, 3);
    repeat (30) @(negedge osc_clk);
    blank_in = 1'b1;
    repeat (10) @(negedge osc_clk);

    // R6 R10 field change mid-window
    @(negedge osc_clk);
    cur_sel = 2'b10; win_sel = 2'b01;
    clear_mon();
    @(negedge osc_clk) blank_in = 1'b0;
    repeat (8) @(negedge osc_clk);
    cur_sel = 2'b11; win_sel = 2'b11;
    repeat (150) @(negedge osc_clk);
    blank_in = 1'b1;
    repeat (12) @(negedge osc_clk);
    check("R10 length held", sink_cnt, 33);
    check("R6 code held", int'(first_code), 2);
    check("R6 code no drift", code_var, 0);

    // R8 leak hold combinational
    for (int j = 0; j < 8; j++) begin
      oe_mode = j[2]; cur_sel = j[1:0];
      #1;
      check($sformatf("R8 leak hold mode=%0d cur=%0d", j[2], j[1:0]),
            int'(leak_det_hold), int'(j[2] && (j[1:0] != 0)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule